// File: doc/BRIEF.md
# Programmable 24-Line Parallel Port

This block attaches to an 8-bit processor bus and provides 24 general I/O lines. The lines form three 8-bit ports: A, B and C. Port C has two 4-bit halves, and each half has its own direction. A 2-bit register address selects port A, port B, port C or a write-only control register. Chip select, read strobe and write strobe qualify every access.

Writes to the control register use one of two formats, chosen by bit 7 of the data:
- With bit 7 set, the word sets the direction of each port and half.
- With bit 7 clear, the word sets or clears one bit of port C.

Output values are held in latches. Port reads sample the live pins for any port or half that is set as an input. Only basic input/output behaviour is built. The mode-select fields of a configuration word are accepted but have no effect.

On the pin side, each port has three vectors of its own: input, output and output-enable.

Top module: `pio24_top`

## Requirements
- R1: After reset (rst_ni low), every output-enable bit is 0, so all ports are inputs, and every output latch is 0.
- R2: A write (cs_i and wr_i high at a rising clock edge) goes to the location selected by addr_i. The encoding is 0 = port A, 1 = port B, 2 = port C, 3 = control. A port write loads only that port's latch, in the same edge, whatever the port's direction.
- R3: A control write with bit 7 = 1 sets the directions, where 1 means input:
  - bit 4: port A
  - bit 3: port C upper half
  - bit 1: port B
  - bit 0: port C lower half

  Each port's output-enable vector is all ones when the port or half is an output and all zeros when it is an input. Bits 6..5 and bit 2 have no effect.
- R4: A control write with bit 7 = 1 clears the latches of ports A, B and C to 0.
- R5: A control write with bit 7 = 0 writes bit 0 into port C latch bit d_i[3:1]. Every other latch bit and every direction stays unchanged.
- R6: Without a selected write, all latches and output-enables keep their values.
- R7: A read of port A or port B returns the live input pins when the port is an input, and the latch when it is an output.
- R8: A read of port C returns, for each half separately, the live pins if that half is an input and the latch if it is an output.
- R9: d_oe_o equals cs_i and rd_i. A read at address 3 drives 0x00. When d_oe_o is low, d_o is 0x00.
- R10: With cs_i low, wr_i has no effect on any latch or direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 2 | Register address |
| d_i | input | 8 | Bus write data |
| d_o | output | 8 | Bus read data |
| d_oe_o | output | 1 | Bus read data enable |
| pa_i | input | 8 | Port A pin input |
| pa_o | output | 8 | Port A latch output |
| pa_oe_o | output | 8 | Port A output enable |
| pb_i | input | 8 | Port B pin input |
| pb_o | output | 8 | Port B latch output |
| pb_oe_o | output | 8 | Port B output enable |
| pc_i | input | 8 | Port C pin input |
| pc_o | output | 8 | Port C latch output |
| pc_oe_o | output | 8 | Port C output enable |

## Verification
The bench mixes random writes to all four addresses with random pin values, and reads every address after each step.

- Random configuration words reach all 16 direction combinations. This separates latch read-back from pin sampling on each port and on each half of port C.
- Random set/reset commands hit every bit index with both values. This shows whether a single bit changes or its neighbours are disturbed.
- Directed cases cover the reset state, writes with chip select low, mode fields that must be ignored, and port writes made while the port is an input.

// File: rtl/pio24_pkg.sv
package pio24_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int ADDR_W = 2;
  localparam int IDX_W  = $clog2(PORT_W);

  // control word field positions
  localparam int CW_FMT = 7;
  localparam int CW_A   = 4;
  localparam int CW_CU  = 3;
  localparam int CW_B   = 1;
  localparam int CW_CL  = 0;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // 1 = input
  typedef struct packed {
    logic in_a;
    logic in_b;
    logic in_cu;
    logic in_cl;
  } dir_t;
endpackage

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
  import pio24_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic [PORT_W-1:0] d_i,
  output dir_t              dir_o,
  output logic              cfg_wr_o,
  output logic              bsr_wr_o,
  output logic [IDX_W-1:0]  bsr_idx_o,
  output logic              bsr_val_o
);
  dir_t dir_q;

  assign cfg_wr_o  = wr_ctrl_i &  d_i[CW_FMT];
  assign bsr_wr_o  = wr_ctrl_i & ~d_i[CW_FMT];
  assign bsr_idx_o = d_i[IDX_W:1];
  assign bsr_val_o = d_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '{in_a: 1'b1, in_b: 1'b1, in_cu: 1'b1, in_cl: 1'b1};
    end else if (cfg_wr_o) begin
      dir_q.in_a  <= d_i[CW_A];
      dir_q.in_b  <= d_i[CW_B];
      dir_q.in_cu <= d_i[CW_CU];
      dir_q.in_cl <= d_i[CW_CL];
    end
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/pio24_latch.sv
module pio24_latch #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [W-1:0]     d_i,
  input  logic             bit_wr_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (clr_i)    q_q <= '0;
    else if (wr_i)     q_q <= d_i;
    else if (bit_wr_i) q_q[bit_idx_i] <= bit_val_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pio24_rdmux.sv
module pio24_rdmux
  import pio24_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  dir_t              dir_i,
  input  logic [PORT_W-1:0] la_i,
  input  logic [PORT_W-1:0] lb_i,
  input  logic [PORT_W-1:0] lc_i,
  input  logic [PORT_W-1:0] pa_i,
  input  logic [PORT_W-1:0] pb_i,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] rd_o
);
  logic [PORT_W-1:0] a_v, b_v, c_v;
  logic [1:0]        c_in;

  assign a_v  = dir_i.in_a ? pa_i : la_i;
  assign b_v  = dir_i.in_b ? pb_i : lb_i;
  assign c_in = {dir_i.in_cu, dir_i.in_cl};

  for (genvar h = 0; h < 2; h++) begin : g_c_half
    assign c_v[h*HALF_W +: HALF_W] = c_in[h] ? pc_i[h*HALF_W +: HALF_W]
                                             : lc_i[h*HALF_W +: HALF_W];
  end

  always_comb begin
    unique case (sel_e'(addr_i))
      SEL_A:   rd_o = a_v;
      SEL_B:   rd_o = b_v;
      SEL_C:   rd_o = c_v;
      default: rd_o = '0;
    endcase
  end
endmodule

// File: rtl/pio24_top.sv
module pio24_top
  import pio24_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] d_i,
  output logic [PORT_W-1:0] d_o,
  output logic              d_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  logic             wr_en;
  logic [3:0]       wr_sel;
  dir_t             dir;
  logic             cfg_wr, bsr_wr, bsr_val;
  logic [IDX_W-1:0] bsr_idx;
  logic [PORT_W-1:0] rd_data;

  assign wr_en = cs_i & wr_i;

  for (genvar s = 0; s < 4; s++) begin : g_wsel
    assign wr_sel[s] = wr_en & (addr_i == ADDR_W'(s));
  end

  pio24_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_sel[SEL_CTRL]),
    .d_i       (d_i),
    .dir_o     (dir),
    .cfg_wr_o  (cfg_wr),
    .bsr_wr_o  (bsr_wr),
    .bsr_idx_o (bsr_idx),
    .bsr_val_o (bsr_val)
  );

  pio24_latch #(.W(PORT_W)) i_lat_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cfg_wr), .wr_i(wr_sel[SEL_A]),
    .d_i(d_i), .bit_wr_i(1'b0), .bit_idx_i('0), .bit_val_i(1'b0), .q_o(pa_o)
  );

  pio24_latch #(.W(PORT_W)) i_lat_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cfg_wr), .wr_i(wr_sel[SEL_B]),
    .d_i(d_i), .bit_wr_i(1'b0), .bit_idx_i('0), .bit_val_i(1'b0), .q_o(pb_o)
  );

  pio24_latch #(.W(PORT_W)) i_lat_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cfg_wr), .wr_i(wr_sel[SEL_C]),
    .d_i(d_i), .bit_wr_i(bsr_wr), .bit_idx_i(bsr_idx), .bit_val_i(bsr_val),
    .q_o(pc_o)
  );

  assign pa_oe_o = {PORT_W{~dir.in_a}};
  assign pb_oe_o = {PORT_W{~dir.in_b}};
  assign pc_oe_o = {{HALF_W{~dir.in_cu}}, {HALF_W{~dir.in_cl}}};

  pio24_rdmux i_rdmux (
    .addr_i (addr_i),
    .dir_i  (dir),
    .la_i   (pa_o),
    .lb_i   (pb_o),
    .lc_i   (pc_o),
    .pa_i   (pa_i),
    .pb_i   (pb_i),
    .pc_i   (pc_i),
    .rd_o   (rd_data)
  );

  assign d_oe_o = cs_i & rd_i;
  assign d_o    = d_oe_o ? rd_data : '0;
endmodule

// File: rtl/pio24_chk.sv
module pio24_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic [7:0] d_i,
  input logic [7:0] d_o,
  input logic       d_oe_o,
  input logic [7:0] pa_i,
  input logic [7:0] pa_o,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pb_o,
  input logic [7:0] pb_oe_o,
  input logic [7:0] pc_o,
  input logic [7:0] pc_oe_o
);
  logic wr_ctl;
  assign wr_ctl = cs_i && wr_i && addr_i == 2'd3;

  a_r4_cfg_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl && d_i[7] |=> pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00);

  a_r5_bsr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl && !d_i[7] |=> $countones(pc_o ^ $past(pc_o)) <= 1
                          && $stable(pa_o) && $stable(pb_o) && $stable(pc_oe_o));

  a_r5_bsr_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl && !d_i[7] |=> pc_o[$past(d_i[3:1])] == $past(d_i[0]));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i) |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o)
                        && $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));

  a_r7_input_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_oe_o && addr_i == 2'd0 && pa_oe_o == 8'h00 |-> d_o == pa_i);

  a_r9_ctrl_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_oe_o && addr_i == 2'd3 |-> d_o == 8'h00);
endmodule

bind pio24_top pio24_chk i_pio24_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
  .addr_i(addr_i), .d_i(d_i), .d_o(d_o), .d_oe_o(d_oe_o), .pa_i(pa_i),
  .pa_o(pa_o), .pa_oe_o(pa_oe_o), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
  .pc_o(pc_o), .pc_oe_o(pc_oe_o)
);

// File: tb/test_pio24_top.sv
module test_pio24_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       doe;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_la, m_lb, m_lc;
  logic       m_ina, m_inb, m_incu, m_incl;

  always #2 clk = ~clk;

  pio24_top i_pio24_top (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .d_i(din), .d_o(dout), .d_oe_o(doe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_ina ? pa_i : m_la;
      2'd1: return m_inb ? pb_i : m_lb;
      2'd2: return {m_incu ? pc_i[7:4] : m_lc[7:4], m_incl ? pc_i[3:0] : m_lc[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_oec();
    return {{4{~m_incu}}, {4{~m_incl}}};
  endfunction

  task automatic model_write(logic sel, logic [1:0] a, logic [7:0] d);
    if (!sel) return;
    case (a)
      2'd0: m_la = d;
      2'd1: m_lb = d;
      2'd2: m_lc = d;
      default: begin
        if (d[7]) begin
          m_ina = d[4]; m_incu = d[3]; m_inb = d[1]; m_incl = d[0];
          m_la = '0; m_lb = '0; m_lc = '0;
        end else begin
          m_lc[d[3:1]] = d[0];
        end
      end
    endcase
  endtask

  // drive at negedge, edge captures, check at next negedge
  task automatic bus_wr(logic sel, logic [1:0] a, logic [7:0] d);
    cs = sel; wr = 1'b1; rd = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    model_write(sel, a, d);
  endtask

  task automatic check_pins(string tag);
    chk({tag, " R2/R4/R5/R6 pa_o"}, pa_o, m_la);
    chk({tag, " R2/R4/R5/R6 pb_o"}, pb_o, m_lb);
    chk({tag, " R2/R4/R5/R6 pc_o"}, pc_o, m_lc);
    chk({tag, " R3 pa_oe"}, pa_oe, {8{~m_ina}});
    chk({tag, " R3 pb_oe"}, pb_oe, {8{~m_inb}});
    chk({tag, " R3 pc_oe"}, pc_oe, exp_oec());
  endtask

  task automatic check_reads(string tag);
    for (int a = 0; a < 4; a++) begin
      cs = 1'b1; rd = 1'b1; addr = 2'(a);
      #0.5;
      chk({tag, " R9 doe"}, doe, 1'b1);
      case (a)
        0, 1: chk({tag, " R7 read"}, dout, exp_read(2'(a)));
        2:    chk({tag, " R8 read C"}, dout, exp_read(2'(a)));
        default: chk({tag, " R9 ctrl read"}, dout, 8'h00);
      endcase
    end
    cs = 1'b0; rd = 1'b0;
    #0.5;
    chk({tag, " R9 idle"}, {doe, dout}, 9'h000);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_la = '0; m_lb = '0; m_lc = '0;
    m_ina = 1; m_inb = 1; m_incu = 1; m_incl = 1;
    pa_i = 8'h5A; pb_i = 8'hC3; pc_i = 8'h96;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 oe a", pa_oe, 8'h00);
    chk("R1 oe b", pb_oe, 8'h00);
    chk("R1 oe c", pc_oe, 8'h00);
    chk("R1 latches", {pa_o, pb_o, pc_o}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_reads("R1 inputs");

    // R2: write while input updates latch only
    bus_wr(1, 2'd0, 8'hA5);
    check_pins("R2 A in");
    check_reads("R2 A in");

    // R3: mode fields ignored; A out, B in, C upper out, lower in
    bus_wr(1, 2'd3, 8'b1110_0111 & ~8'b0001_1000 | 8'b0000_0100);
    check_pins("R3 cfg");
    bus_wr(1, 2'd0, 8'h3C);
    bus_wr(1, 2'd2, 8'hE1);
    check_pins("R3 data");
    check_reads("R3 data");

    // R10: no chip select
    bus_wr(0, 2'd0, 8'hFF);
    bus_wr(0, 2'd3, 8'h80);
    check_pins("R10 nocs");

    // R5: BSR edge bits, mode words stay
    bus_wr(1, 2'd3, 8'b0000_1111);
    bus_wr(1, 2'd3, 8'b0000_0000);
    check_pins("R5 bsr");
    check_reads("R5 bsr");

    // R4: config clears latches
    bus_wr(1, 2'd3, 8'h80);
    check_pins("R4 clear");
    check_reads("R4 clear");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic       sel;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      sel = ($urandom_range(0, 9) != 0);
      if (a == 2'd3 && $urandom_range(0, 3) != 0) d[7] = 1'b0;
      pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
      bus_wr(sel, a, d);
      check_pins("R6 rnd");
      check_reads("R7/R8 rnd");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule